// File: doc/BRIEF.md
# Byte-Wide Configuration Write Port

This block lets a host processor push configuration data into a device one byte at a time, as if the device were an ordinary memory-mapped peripheral. The host performs a normal bus write. The port recognises the write from a strobe and three chip-select lines, keeps the byte, and sends it out on a serial data line. The serial data is timed by a configuration clock that the port makes itself from its own timing divider, so the port can drive a chain of downstream loaders.

A single status pin tells the host when the next byte can be written. The host polls or waits on it: high means the input register is free, and low means the current byte is still being shifted out. The bus pins are asynchronous to the port clock. They are synchronised inside before they are decoded. The host keeps the data bus stable until a few port-clock cycles after it releases the strobe.

Top module: `cfg_byte_port`

## Requirements
- R1: A write is accepted only when the strobe `wr_n` is 0, `sel_a_n` is 0, `sel_b_n` is 0 and `sel_c` is 1, all at the same time. Any other chip-select combination produces no serial output, and `ready` stays high.
- R2: Each strobe accepts at most one byte. The byte is committed when the synchronised strobe returns high, however long the strobe was held low.
- R3: Each accepted byte produces exactly eight rising edges of `cclk`. `cclk` is derived from the port clock: each high or low phase lasts `CCLK_HALF` port-clock cycles.
- R4: `ready` is 1 while the input register can take a byte. It goes to 0 in the cycle after a byte is accepted, and returns to 1 only after the eighth falling edge of `cclk`.
- R5: Between bursts and after reset, `cclk` is 0 and `sdo` is 1.
- R6: A write that arrives while `ready` is 0 is discarded. The byte already in flight is sent unchanged, and no extra burst follows it.
- R7: Bits leave on `sdo` most significant bit first. `sdo` holds steady while `cclk` is high and changes only after a falling edge, so a downstream receiver can sample it on the rising edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Port clock; source of the configuration clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_n | input | 1 | Host write strobe, active low |
| sel_a_n | input | 1 | First chip select, active low |
| sel_b_n | input | 1 | Second chip select, active low |
| sel_c | input | 1 | Third chip select, active high |
| wdata | input | DATA_W | Host data bus |
| ready | output | 1 | 1 = input register free, 0 = busy serialising |
| cclk | output | 1 | Generated configuration clock |
| sdo | output | 1 | Serial configuration data |

## Verification
Two functions can fall in the same cycle: the decoder accepting a new strobe, and the serialiser advancing on a divider tick while busy. The bench provokes this by issuing a second valid write immediately after the first has been accepted, so that the second acceptance lands in the middle of the first burst. The result is judged at the pins. The reassembled serial byte must equal the first byte, exactly eight clock pulses must appear, and no further pulse may follow once `ready` returns. Randomised bytes and chip-select patterns, with strobe widths of varying length, exercise the decode and the one-byte-per-strobe rule alongside this case.

// File: rtl/cbp_pkg.sv
package cbp_pkg;
  typedef struct packed {
    logic wr_n;
    logic sa_n;
    logic sb_n;
    logic sc;
  } bus_ctl_t;

  localparam bus_ctl_t BUS_IDLE = '{wr_n: 1'b1, sa_n: 1'b1, sb_n: 1'b1, sc: 1'b0};
endpackage

// File: rtl/cbp_wr_decode.sv
module cbp_wr_decode
  import cbp_pkg::*;
#(
  parameter int DATA_W   = 8,
  parameter int SYNC_LEN = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  bus_ctl_t          ctl_raw,
  input  logic [DATA_W-1:0] wdata,
  output logic              accept,
  output logic [DATA_W-1:0] byte_q
);
  bus_ctl_t sync_q [SYNC_LEN];
  bus_ctl_t s;
  logic     prev_wr_n;
  logic     armed;
  logic     sel_now;

  generate
    for (genvar i = 0; i < SYNC_LEN; i++) begin : g_sync
      always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sync_q[i] <= BUS_IDLE;
        else if (i == 0) sync_q[i] <= ctl_raw;
        else sync_q[i] <= sync_q[i-1];
      end
    end
  endgenerate

  assign s       = sync_q[SYNC_LEN-1];
  assign sel_now = !s.wr_n && !s.sa_n && !s.sb_n && s.sc;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      prev_wr_n <= 1'b1;
      armed     <= 1'b0;
      accept    <= 1'b0;
      byte_q    <= '0;
    end else begin
      prev_wr_n <= s.wr_n;
      accept    <= s.wr_n && !prev_wr_n && armed;
      if (sel_now) begin
        armed  <= 1'b1;
        byte_q <= wdata;
      end else if (s.wr_n) begin
        armed  <= 1'b0;
      end
    end
  end

  // one acceptance per strobe: never two in a row
  p_single_accept_r2: assert property (@(posedge clk) disable iff (!rst_n)
    accept |=> !accept);
endmodule

// File: rtl/cbp_tick_gen.sv
module cbp_tick_gen #(
  parameter int CCLK_HALF = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic en,
  output logic tick
);
  localparam int CW = (CCLK_HALF > 1) ? $clog2(CCLK_HALF) : 1;
  localparam logic [CW-1:0] LAST = CW'(CCLK_HALF - 1);

  logic [CW-1:0] cnt;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) cnt <= '0;
    else if (!en || cnt == LAST) cnt <= '0;
    else cnt <= cnt + 1'b1;
  end

  assign tick = en && (cnt == LAST);
endmodule

// File: rtl/cbp_shifter.sv
module cbp_shifter #(
  parameter int DATA_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              load,
  input  logic [DATA_W-1:0] load_data,
  input  logic              tick,
  output logic              busy,
  output logic              cclk,
  output logic              sdo
);
  localparam int BW = (DATA_W > 1) ? $clog2(DATA_W) : 1;
  localparam logic [BW-1:0] LAST_BIT = BW'(DATA_W - 1);

  logic [DATA_W-1:0] sh;
  logic [BW-1:0]     bits;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      cclk <= 1'b0;
      sh   <= '0;
      bits <= '0;
    end else if (load && !busy) begin
      busy <= 1'b1;
      cclk <= 1'b0;
      sh   <= load_data;
      bits <= '0;
    end else if (busy && tick) begin
      if (!cclk) begin
        cclk <= 1'b1;
      end else begin
        cclk <= 1'b0;
        if (bits == LAST_BIT) begin
          busy <= 1'b0;
        end else begin
          sh   <= sh << 1;
          bits <= bits + 1'b1;
        end
      end
    end
  end

  assign sdo = busy ? sh[DATA_W-1] : 1'b1;

  p_idle_lines_r5: assert property (@(posedge clk) disable iff (!rst_n)
    !busy |-> (!cclk && sdo));
  p_load_goes_busy_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (load && !busy) |=> busy);
  p_busy_write_ignored_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (load && busy && !tick) |=> $stable(sh) && $stable(bits));
  p_sdo_steady_high_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (cclk && $past(cclk)) |-> $stable(sdo));
endmodule

// File: rtl/cfg_byte_port.sv
module cfg_byte_port
  import cbp_pkg::*;
#(
  parameter int DATA_W    = 8,
  parameter int CCLK_HALF = 2,
  parameter int SYNC_LEN  = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_n,
  input  logic              sel_a_n,
  input  logic              sel_b_n,
  input  logic              sel_c,
  input  logic [DATA_W-1:0] wdata,
  output logic              ready,
  output logic              cclk,
  output logic              sdo
);
  bus_ctl_t          ctl_raw;
  logic              accept;
  logic [DATA_W-1:0] byte_q;
  logic              busy;
  logic              tick;

  assign ctl_raw = '{wr_n: wr_n, sa_n: sel_a_n, sb_n: sel_b_n, sc: sel_c};

  cbp_wr_decode #(.DATA_W(DATA_W), .SYNC_LEN(SYNC_LEN)) u_dec (
    .clk(clk), .rst_n(rst_n), .ctl_raw(ctl_raw), .wdata(wdata),
    .accept(accept), .byte_q(byte_q)
  );

  cbp_tick_gen #(.CCLK_HALF(CCLK_HALF)) u_tick (
    .clk(clk), .rst_n(rst_n), .en(busy), .tick(tick)
  );

  cbp_shifter #(.DATA_W(DATA_W)) u_sh (
    .clk(clk), .rst_n(rst_n), .load(accept), .load_data(byte_q),
    .tick(tick), .busy(busy), .cclk(cclk), .sdo(sdo)
  );

  assign ready = !busy;

  // cclk only moves while a burst is running
  p_cclk_only_busy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    ready |=> (!cclk || !ready));
endmodule

// File: tb/tb_cfg_byte_port.sv
`timescale 1ns/1ps
module tb_cfg_byte_port;
  localparam int DATA_W = 8;
  localparam int CCLK_HALF = 2;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic wr_n = 1'b1, sel_a_n = 1'b1, sel_b_n = 1'b1, sel_c = 1'b0;
  logic [DATA_W-1:0] wdata = '0;
  logic ready, cclk, sdo;

  int checks = 0, failures = 0;
  bit finished = 0;

  // bench monitor state
  int   rises = 0, hi_len = 0, lo_len = 0, r7_bad = 0, r3_bad = 0;
  logic prev_cclk = 1'b0, prev_sdo = 1'b1;
  logic [DATA_W-1:0] got = '0;

  always #2 clk = ~clk;

  cfg_byte_port #(.DATA_W(DATA_W), .CCLK_HALF(CCLK_HALF)) dut (
    .clk(clk), .rst_n(rst_n), .wr_n(wr_n), .sel_a_n(sel_a_n), .sel_b_n(sel_b_n),
    .sel_c(sel_c), .wdata(wdata), .ready(ready), .cclk(cclk), .sdo(sdo)
  );

  always @(negedge clk) begin
    if (rst_n) begin
      if (cclk && !prev_cclk) begin
        rises++;
        got = {got[DATA_W-2:0], sdo};
        if (lo_len != CCLK_HALF && rises > 1) r3_bad++;
        hi_len = 1;
      end else if (cclk) begin
        hi_len++;
        if (sdo !== prev_sdo) r7_bad++;
      end
      if (!cclk && prev_cclk) begin
        if (hi_len != CCLK_HALF) r3_bad++;
        lo_len = 1;
      end else if (!cclk) lo_len++;
      prev_cclk = cclk;
      prev_sdo = sdo;
    end
  end

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic bit decode_ok(input logic a_n, input logic b_n, input logic c);
    return (!a_n && !b_n && c);
  endfunction

  task automatic bus_write(input logic [DATA_W-1:0] d, input logic a_n,
                           input logic b_n, input logic c, input int low_len);
    @(negedge clk);
    wdata = d; sel_a_n = a_n; sel_b_n = b_n; sel_c = c; wr_n = 1'b0;
    repeat (low_len) @(negedge clk);
    wr_n = 1'b1;
    repeat (4) @(negedge clk);
    sel_a_n = 1'b1; sel_b_n = 1'b1; sel_c = 1'b0;
  endtask

  task automatic clear_mon();
    rises = 0; got = '0;
  endtask

  task automatic wait_ready(input int limit, output bit ok);
    ok = 0;
    for (int i = 0; i < limit; i++) begin
      @(negedge clk);
      if (ready) begin ok = 1; break; end
    end
  endtask

  task automatic expect_burst(input logic [DATA_W-1:0] d, input string tag);
    bit ok;
    wait_ready(400, ok);
    check(ok, {tag, " ready return (R4)"}, ok, 1);
    check(rises == 8, {tag, " eight pulses (R3)"}, rises, 8);
    check(got == d, {tag, " msb-first byte (R7)"}, got, d);
    check(!cclk && sdo, {tag, " idle lines (R5)"}, {cclk, sdo}, 2'b01);
  endtask

  task automatic expect_none(input string tag);
    repeat (40) @(negedge clk);
    check(rises == 0 && ready, {tag, " rejected write (R1)"}, rises, 0);
  endtask

  initial begin
    #(200000 * 4);
    if (!finished) begin
      failures++;
      checks++;
      $display("FAIL watchdog actual=timeout expected=done");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end

  initial begin
    bit ok;
    void'($urandom(32'h00c0ffee));
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    check(ready && !cclk && sdo, "reset idle R5 R4", {ready, cclk, sdo}, 3'b101);

    // R1 / R3 / R7: directed valid write
    clear_mon();
    bus_write(8'hA5, 1'b0, 1'b0, 1'b1, 3);
    check(!ready, "busy after accept R4", ready, 0);
    expect_burst(8'hA5, "directed");

    // R1: each single wrong select is rejected
    clear_mon(); bus_write(8'h3C, 1'b1, 1'b0, 1'b1, 3); expect_none("sel_a high");
    clear_mon(); bus_write(8'h3C, 1'b0, 1'b1, 1'b1, 3); expect_none("sel_b high");
    clear_mon(); bus_write(8'h3C, 1'b0, 1'b0, 1'b0, 3); expect_none("sel_c low");

    // R2: very long strobe still gives one byte
    clear_mon();
    bus_write(8'h81, 1'b0, 1'b0, 1'b1, 60);
    expect_burst(8'h81, "long strobe R2");
    repeat (40) @(negedge clk);
    check(rises == 8, "single byte per strobe R2", rises, 8);

    // R6: second write during busy is ignored
    clear_mon();
    bus_write(8'hC3, 1'b0, 1'b0, 1'b1, 2);
    check(!ready, "busy before overlap R6", ready, 0);
    bus_write(8'h5A, 1'b0, 1'b0, 1'b1, 2);
    expect_burst(8'hC3, "overlap R6");
    repeat (40) @(negedge clk);
    check(rises == 8 && ready, "no extra burst R6", rises, 8);

    // random mix
    for (int n = 0; n < 24; n++) begin
      logic [DATA_W-1:0] d;
      logic a_n, b_n, c;
      int pick;
      d = DATA_W'($urandom);
      pick = $urandom % 6;
      a_n = (pick == 0); b_n = (pick == 1); c = (pick != 2);
      clear_mon();
      bus_write(d, a_n, b_n, c, 1 + ($urandom % 8));
      if (decode_ok(a_n, b_n, c)) expect_burst(d, "random R1");
      else expect_none("random R1");
    end

    check(r7_bad == 0, "sdo steady while cclk high R7", r7_bad, 0);
    check(r3_bad == 0, "cclk phase length R3", r3_bad, 0);

    finished = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule